// File: doc/BRIEF.md
# Source Interrupt Hub with Byte-Lane Register File

This block gathers up to 64 interrupt sources and drives one output line per source toward an upstream interrupt controller. Each source can be set to edge or level capture and to active-high or active-low polarity, and can be masked on its own. Software reaches the configuration and state through a memory-mapped register file of 64-bit words. Any access of 1, 2, 4 or 8 bytes works, provided it is naturally aligned.

Every source also owns two byte-wide slots: a routing byte and a message-vector byte. The block stores these for logic outside it. A per-source message-enable bit is stored the same way. Message generation and the upstream controller are not part of the block.

The bus is a request/response port. A request is taken in one cycle and its response comes back in the next cycle.

Top module: `src_irq_hub`

## Requirements
- R1: After a synchronous active-low reset, every mask bit is 1. Edge select, message enable, polarity, all pending and in-service state, and every routing and vector byte are 0. irq_out is all zero.
- R2: The ID word at offset 0x000 reads as 0x07 in byte 3, 0x01 in byte 4 and NSRC-1 in byte 6. Its other bytes read 0.
- R3: req_size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. A read returns the addressed 64-bit word shifted right by 8×req_addr[2:0], masked to the access width.
- R4: A write changes only the bytes it covers. The covered bytes take req_wdata starting at byte req_addr[2:0], and the other bytes of the word keep their values. Writable words are mask 0x020, message enable 0x040, edge select 0x060 and polarity 0x3E0.
- R5: An access whose address is not a multiple of its width returns rsp_err=1 with zero read data and changes no state.
- R6: Reads of unmapped addresses, of the fixed-zero words 0x0C0 and 0x0E0, and of the clear word 0x080 return 0. Writes to unmapped addresses and to 0x0C0 or 0x0E0 change nothing. None of these accesses raises rsp_err.
- R7: For an edge source (edge-select bit 1), a rising effective input sets its pending bit, and the bit stays set until it is cleared. irq_out[n] is the pending bit of source n while it is unmasked.
- R8: For a level source (edge-select bit 0), the pending bit follows the effective input with one cycle of delay.
- R9: A polarity bit of 1 inverts that source's input before capture.
- R10: A write to the clear word 0x080 clears pending and in-service state only for sources whose edge-select bit is 1. Bits of level sources are ignored.
- R11: After a write that clears a mask bit, a pending source's output is asserted in the next cycle. After a write that sets a mask bit, the output is deasserted in the next cycle, and the pending state is kept.
- R12: The status word 0x3A0 reads as in-service AND NOT mask. In-service is set once a source is delivered unmasked. It follows delivery for level sources and is held for edge sources until they are cleared.
- R13: rsp_valid is 1 exactly in the cycle after a cycle with req_valid=1.
- R14: The routing byte of source n is at 0x100+n and its vector byte is at 0x200+n. Both can be read and written at any access width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NSRC | Raw interrupt inputs |
| irq_out | output | NSRC | Per-source outputs toward the upstream controller |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access width code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_wdata | input | 64 | Write data, least significant byte first |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Misaligned access flag |
| rsp_rdata | output | 64 | Read data, right-aligned |

## Verification
Two conditions are the hardest to reach from the ports. The first is an edge source that is pending and in service while it is masked, then unmasked. The second is a clear write that covers a level source whose input is still high. To reach them, the bench programs edge select and mask one byte at a time, pulses an input for a single cycle, and then toggles the mask. It reads the status word in each of these states. Polarity and level capture are reached by leaving an input held low or high across several accesses.

// File: rtl/src_irq_hub_pkg.sv
// Shared constants and helpers for the source interrupt hub.
// Assumes a 64-bit register word and addresses of at least 12 bits.
package src_irq_hub_pkg;
    localparam int WORD_W  = 64;
    localparam int LANES   = WORD_W / 8;

    localparam logic [11:0] OFF_ID       = 12'h000;
    localparam logic [11:0] OFF_MASK     = 12'h020;
    localparam logic [11:0] OFF_MSIEN    = 12'h040;
    localparam logic [11:0] OFF_EDGE     = 12'h060;
    localparam logic [11:0] OFF_CLEAR    = 12'h080;
    localparam logic [11:0] OFF_FIX0     = 12'h0C0;
    localparam logic [11:0] OFF_FIX1     = 12'h0E0;
    localparam logic [11:0] OFF_ROUTE    = 12'h100;
    localparam logic [11:0] OFF_ROUTE_HI = 12'h13F;
    localparam logic [11:0] OFF_VEC      = 12'h200;
    localparam logic [11:0] OFF_VEC_HI   = 12'h23F;
    localparam logic [11:0] OFF_STATUS   = 12'h3A0;
    localparam logic [11:0] OFF_POL      = 12'h3E0;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_ID, SEL_MASK, SEL_MSIEN, SEL_EDGE, SEL_CLEAR,
        SEL_FIXED, SEL_ROUTE, SEL_VEC, SEL_STATUS, SEL_POL
    } reg_sel_e;

    // Byte-lane enables of an access at byte offset zero
    function automatic logic [LANES-1:0] width_lanes(input logic [1:0] sz);
        case (sz)
            2'd0:    return LANES'(8'h01);
            2'd1:    return LANES'(8'h03);
            2'd2:    return LANES'(8'h0F);
            default: return '1;
        endcase
    endfunction

    // Expand byte-lane enables into a bit mask
    function automatic logic [WORD_W-1:0] lanes_to_bits(input logic [LANES-1:0] l);
        logic [WORD_W-1:0] b;
        for (int i = 0; i < LANES; i++) b[i*8 +: 8] = {8{l[i]}};
        return b;
    endfunction
endpackage

// File: rtl/sih_decode.sv
// Access decoder: picks the target register, checks alignment, and
// builds the lane mask and lane-aligned write data of one access.
// Pure combinational; assumes ADDR_W >= 12.
module sih_decode
    import src_irq_hub_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [WORD_W-1:0] wdata,
    output reg_sel_e          sel,
    output logic              misalign,
    output logic [2:0]        byte_off,
    output logic [2:0]        word_idx,
    output logic [LANES-1:0]  lane_en,
    output logic [WORD_W-1:0] bit_mask,
    output logic [WORD_W-1:0] wdata_sh,
    output logic [WORD_W-1:0] size_bits
);
    logic [ADDR_W-1:0] word_addr;

    assign word_addr = {addr[ADDR_W-1:3], 3'b000};
    assign byte_off  = addr[2:0];
    assign word_idx  = addr[5:3];
    assign size_bits = lanes_to_bits(width_lanes(size));
    assign lane_en   = width_lanes(size) << byte_off;
    assign bit_mask  = size_bits << {byte_off, 3'b000};
    assign wdata_sh  = (wdata & size_bits) << {byte_off, 3'b000};

    // Alignment rule: the offset must be a multiple of the access width
    always_comb begin
        case (size)
            2'd0:    misalign = 1'b0;
            2'd1:    misalign = addr[0];
            2'd2:    misalign = |addr[1:0];
            default: misalign = |addr[2:0];
        endcase
    end

    // Word address to register selection
    always_comb begin
        sel = SEL_NONE;
        if (word_addr == ADDR_W'(OFF_ID))          sel = SEL_ID;
        else if (word_addr == ADDR_W'(OFF_MASK))   sel = SEL_MASK;
        else if (word_addr == ADDR_W'(OFF_MSIEN))  sel = SEL_MSIEN;
        else if (word_addr == ADDR_W'(OFF_EDGE))   sel = SEL_EDGE;
        else if (word_addr == ADDR_W'(OFF_CLEAR))  sel = SEL_CLEAR;
        else if (word_addr == ADDR_W'(OFF_FIX0) ||
                 word_addr == ADDR_W'(OFF_FIX1))   sel = SEL_FIXED;
        else if (word_addr >= ADDR_W'(OFF_ROUTE) &&
                 word_addr <= ADDR_W'(OFF_ROUTE_HI)) sel = SEL_ROUTE;
        else if (word_addr >= ADDR_W'(OFF_VEC) &&
                 word_addr <= ADDR_W'(OFF_VEC_HI))   sel = SEL_VEC;
        else if (word_addr == ADDR_W'(OFF_STATUS)) sel = SEL_STATUS;
        else if (word_addr == ADDR_W'(OFF_POL))    sel = SEL_POL;
    end
endmodule

// File: rtl/sih_bytes.sv
// Byte-per-source storage (routing or vector bytes), eight words of
// eight bytes. Slots at or above NSRC are not stored and read as zero.
// Assumes NSRC <= 64.
module sih_bytes
    import src_irq_hub_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        word_idx,
    input  logic [LANES-1:0]  lane_en,
    input  logic [WORD_W-1:0] wdata_sh,
    output logic [WORD_W-1:0] rd_word
);
    localparam int SLOTS = 8 * LANES;

    logic [7:0]         mem [NSRC];
    logic [SLOTS*8-1:0] flat;

    // Byte-lane write into the addressed word, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NSRC; n++) mem[n] <= 8'h00;
        end else if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_en[l] && (int'(word_idx) * LANES + l) < NSRC)
                    mem[int'(word_idx) * LANES + l] <= wdata_sh[l*8 +: 8];
            end
        end
    end

    for (genvar n = 0; n < SLOTS; n++) begin : g_slot
        if (n < NSRC) begin : g_live
            assign flat[n*8 +: 8] = mem[n];
        end else begin : g_none
            assign flat[n*8 +: 8] = 8'h00;
        end
    end

    assign rd_word = flat[word_idx*WORD_W +: WORD_W];
endmodule

// File: rtl/sih_line.sv
// Capture logic of one interrupt source: polarity inversion, edge or
// level capture into a pending bit, and the in-service latch.
// On an edge source, a new rising edge in the same cycle as a clear
// leaves the pending bit set.
module sih_line (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic invert,
    input  logic is_edge,
    input  logic masked,
    input  logic clr,
    output logic pend,
    output logic isr
);
    logic eff;
    logic prev;

    assign eff = raw_in ^ invert;

    // Pending and in-service update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            pend <= 1'b0;
            isr  <= 1'b0;
        end else begin
            prev <= eff;
            pend <= is_edge ? ((pend & ~clr) | (eff & ~prev)) : eff;
            isr  <= is_edge ? (clr ? 1'b0 : (isr | (pend & ~masked)))
                            : (pend & ~masked);
        end
    end
endmodule

// File: rtl/src_irq_hub.sv
// Source interrupt hub top: 64-bit register file with byte-lane access,
// per-source capture lines, and a registered response.
// Assumes NSRC <= 64. Outputs are combinational from registered state.
module src_irq_hub
    import src_irq_hub_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    output logic [NSRC-1:0]   irq_out,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_rdata
);
    localparam logic [WORD_W-1:0] ID_WORD =
        {8'h00, 8'(NSRC - 1), 8'h00, 8'h01, 8'h07, 24'h000000};

    reg_sel_e          sel;
    logic              misalign;
    logic [2:0]        byte_off;
    logic [2:0]        word_idx;
    logic [LANES-1:0]  lane_en;
    logic [WORD_W-1:0] bit_mask;
    logic [WORD_W-1:0] wdata_sh;
    logic [WORD_W-1:0] size_bits;

    logic [NSRC-1:0]   mask_q;
    logic [NSRC-1:0]   edge_q;
    logic [NSRC-1:0]   msien_q;
    logic [NSRC-1:0]   pol_q;
    logic [NSRC-1:0]   pend_q;
    logic [NSRC-1:0]   isr_q;
    logic [NSRC-1:0]   clr_bits;
    logic [NSRC-1:0]   keep;
    logic [NSRC-1:0]   put;

    logic              wr_go;
    logic [WORD_W-1:0] route_rd;
    logic [WORD_W-1:0] vec_rd;
    logic [WORD_W-1:0] word_rd;
    logic [WORD_W-1:0] data_rd;

    sih_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr     (req_addr),
        .size     (req_size),
        .wdata    (req_wdata),
        .sel      (sel),
        .misalign (misalign),
        .byte_off (byte_off),
        .word_idx (word_idx),
        .lane_en  (lane_en),
        .bit_mask (bit_mask),
        .wdata_sh (wdata_sh),
        .size_bits(size_bits)
    );

    assign wr_go    = req_valid & req_write & ~misalign;
    assign keep     = ~bit_mask[NSRC-1:0];
    assign put      = wdata_sh[NSRC-1:0];
    assign clr_bits = (wr_go && sel == SEL_CLEAR) ? (put & edge_q) : '0;

    // Configuration words: byte-lane merge on aligned writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            edge_q  <= '0;
            msien_q <= '0;
            pol_q   <= '0;
        end else if (wr_go) begin
            case (sel)
                SEL_MASK:  mask_q  <= (mask_q  & keep) | put;
                SEL_EDGE:  edge_q  <= (edge_q  & keep) | put;
                SEL_MSIEN: msien_q <= (msien_q & keep) | put;
                SEL_POL:   pol_q   <= (pol_q   & keep) | put;
                default: ;
            endcase
        end
    end

    sih_bytes #(.NSRC(NSRC)) route_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_go && sel == SEL_ROUTE),
        .word_idx(word_idx),
        .lane_en (lane_en),
        .wdata_sh(wdata_sh),
        .rd_word (route_rd)
    );

    sih_bytes #(.NSRC(NSRC)) vec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_go && sel == SEL_VEC),
        .word_idx(word_idx),
        .lane_en (lane_en),
        .wdata_sh(wdata_sh),
        .rd_word (vec_rd)
    );

    for (genvar n = 0; n < NSRC; n++) begin : g_line
        sih_line line_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_in (irq_in[n]),
            .invert (pol_q[n]),
            .is_edge(edge_q[n]),
            .masked (mask_q[n]),
            .clr    (clr_bits[n]),
            .pend   (pend_q[n]),
            .isr    (isr_q[n])
        );
    end

    assign irq_out = pend_q & ~mask_q;

    // Read word selection
    always_comb begin
        case (sel)
            SEL_ID:     word_rd = ID_WORD;
            SEL_MASK:   word_rd = WORD_W'(mask_q);
            SEL_MSIEN:  word_rd = WORD_W'(msien_q);
            SEL_EDGE:   word_rd = WORD_W'(edge_q);
            SEL_STATUS: word_rd = WORD_W'(isr_q & ~mask_q);
            SEL_POL:    word_rd = WORD_W'(pol_q);
            SEL_ROUTE:  word_rd = route_rd;
            SEL_VEC:    word_rd = vec_rd;
            default:    word_rd = '0;
        endcase
    end

    assign data_rd = (word_rd >> {byte_off, 3'b000}) & size_bits;

    // Registered response one cycle after each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid & misalign;
            rsp_rdata <= (req_valid && !req_write && !misalign) ? data_rd : '0;
        end
    end
endmodule

// File: rtl/sih_chk.sv
// Property checker for the source interrupt hub, bound to the top.
module sih_chk #(
    parameter int NSRC   = 64,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata,
    input logic [NSRC-1:0]   irq_out,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   edge_q,
    input logic [NSRC-1:0]   pend_q
);
    logic misal;
    assign misal = (req_size == 2'd1 && req_addr[0]) ||
                   (req_size == 2'd2 && req_addr[1:0] != 2'b00) ||
                   (req_size == 2'd3 && req_addr[2:0] != 3'b000);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1 && edge_q == '0 && irq_out == '0));

    // R13
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R13
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R5
    misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misal) |=> (rsp_err && rsp_rdata == '0));

    // R5
    misalign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && misal) |=> ($stable(mask_q) && $stable(edge_q)));

    // R7
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=>
        ((pend_q & $past(pend_q & edge_q)) == $past(pend_q & edge_q)));
endmodule

bind src_irq_hub sih_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/src_irq_hub_tb_top.sv
module src_irq_hub_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;
    localparam int AW   = 12;
    localparam int VW   = 148;
    localparam int NVEC = 28;

    // {req[3:0], wr, addr[11:0], size[1:0], wdata[63:0], exp[63:0], experr}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {4'd2,  1'b0, 12'h000, 2'd3, 64'h0, 64'h003F_0001_0700_0000, 1'b0}, // R2
        {4'd2,  1'b0, 12'h003, 2'd0, 64'h0, 64'h07, 1'b0},                  // R2
        {4'd3,  1'b0, 12'h006, 2'd1, 64'h0, 64'h003F, 1'b0},                // R3
        {4'd1,  1'b0, 12'h020, 2'd3, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, // R1
        {4'd1,  1'b0, 12'h040, 2'd3, 64'h0, 64'h0, 1'b0},                   // R1
        {4'd4,  1'b1, 12'h064, 2'd2, 64'hF0, 64'h0, 1'b0},                  // R4
        {4'd4,  1'b0, 12'h060, 2'd3, 64'h0, 64'h0000_00F0_0000_0000, 1'b0}, // R4
        {4'd4,  1'b1, 12'h022, 2'd1, 64'h1234, 64'h0, 1'b0},                // R4
        {4'd4,  1'b0, 12'h020, 2'd3, 64'h0, 64'hFFFF_FFFF_1234_FFFF, 1'b0}, // R4
        {4'd3,  1'b0, 12'h023, 2'd0, 64'h0, 64'h12, 1'b0},                  // R3
        {4'd5,  1'b1, 12'h021, 2'd1, 64'h0, 64'h0, 1'b1},                   // R5
        {4'd5,  1'b0, 12'h020, 2'd3, 64'h0, 64'hFFFF_FFFF_1234_FFFF, 1'b0}, // R5
        {4'd5,  1'b0, 12'h044, 2'd3, 64'h0, 64'h0, 1'b1},                   // R5
        {4'd14, 1'b1, 12'h105, 2'd0, 64'hA5, 64'h0, 1'b0},                  // R14
        {4'd14, 1'b0, 12'h100, 2'd3, 64'h0, 64'h0000_A500_0000_0000, 1'b0}, // R14
        {4'd14, 1'b1, 12'h208, 2'd3, 64'h0807_0605_0403_0201, 64'h0, 1'b0}, // R14
        {4'd14, 1'b0, 12'h20A, 2'd0, 64'h0, 64'h03, 1'b0},                  // R14
        {4'd6,  1'b1, 12'h0C0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0}, // R6
        {4'd6,  1'b0, 12'h0C0, 2'd3, 64'h0, 64'h0, 1'b0},                   // R6
        {4'd6,  1'b1, 12'h300, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0}, // R6
        {4'd6,  1'b0, 12'h300, 2'd3, 64'h0, 64'h0, 1'b0},                   // R6
        {4'd4,  1'b1, 12'h040, 2'd2, 64'hDEAD_BEEF, 64'h0, 1'b0},           // R4
        {4'd4,  1'b0, 12'h040, 2'd3, 64'h0, 64'h0000_0000_DEAD_BEEF, 1'b0}, // R4
        {4'd6,  1'b0, 12'h080, 2'd3, 64'h0, 64'h0, 1'b0},                   // R6
        {4'd1,  1'b0, 12'h3E0, 2'd3, 64'h0, 64'h0, 1'b0},                   // R1
        {4'd12, 1'b0, 12'h3A0, 2'd3, 64'h0, 64'h0, 1'b0},                   // R12
        {4'd4,  1'b1, 12'h020, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0}, // R4
        {4'd4,  1'b1, 12'h060, 2'd3, 64'h0, 64'h0, 1'b0}                    // R4
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_in = '0;
    logic [NSRC-1:0] irq_out;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [1:0]      req_size = '0;
    logic [63:0]     req_wdata = '0;
    logic            rsp_valid;
    logic            rsp_err;
    logic [63:0]     rsp_rdata;

    int checks = 0;
    int errors = 0;
    logic [63:0] rd;
    logic        er;
    logic        rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    src_irq_hub #(.NSRC(NSRC), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [AW-1:0] a, input logic [1:0] s,
                          input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd = rsp_rdata; er = rsp_err; rv = rsp_valid;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state at the ports
        check("R1 irq_out after reset", 64'(irq_out), 64'h0);
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);
        rst_n = 1'b1;
        idle(2);

        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            access(v[143], v[142:131], v[130:129], v[128:65]);
            check($sformatf("R13 vec %0d rsp_valid", i), 64'(rv), 64'h1);
            check($sformatf("R%0d vec %0d err", v[147:144], i), 64'(er), 64'(v[0]));
            if (!v[143])
                check($sformatf("R%0d vec %0d rdata", v[147:144], i), rd, v[64:1]);
        end

        // R7 edge source 5
        access(1'b1, 12'h060, 2'd0, 64'h20);
        access(1'b1, 12'h020, 2'd0, 64'hDF);
        @(negedge clk) irq_in[5] = 1'b1;
        @(negedge clk) irq_in[5] = 1'b0;
        idle(1);
        check("R7 edge output set", 64'(irq_out[5]), 64'h1);
        idle(3);
        check("R7 edge output held", 64'(irq_out[5]), 64'h1);
        access(1'b0, 12'h3A0, 2'd0, 64'h0);
        check("R12 status edge in service", rd, 64'h20);
        // R10 clear on edge source
        access(1'b1, 12'h080, 2'd0, 64'h20);
        check("R10 clear drops edge output", 64'(irq_out[5]), 64'h0);
        access(1'b0, 12'h3A0, 2'd0, 64'h0);
        check("R10 status after clear", rd, 64'h0);

        // R11 mask toggling on a pending edge source
        @(negedge clk) irq_in[5] = 1'b1;
        @(negedge clk) irq_in[5] = 1'b0;
        idle(2);
        access(1'b1, 12'h020, 2'd0, 64'hFF);
        check("R11 masking drops output", 64'(irq_out[5]), 64'h0);
        access(1'b0, 12'h3A0, 2'd0, 64'h0);
        check("R12 status hidden while masked", rd, 64'h0);
        access(1'b1, 12'h020, 2'd0, 64'hDF);
        check("R11 unmasking restores output", 64'(irq_out[5]), 64'h1);
        access(1'b1, 12'h080, 2'd0, 64'h20);

        // R8 level source 9
        access(1'b1, 12'h021, 2'd0, 64'hFD);
        @(negedge clk) irq_in[9] = 1'b1;
        idle(2);
        check("R8 level output follows high", 64'(irq_out[9]), 64'h1);
        access(1'b1, 12'h081, 2'd0, 64'h02);
        idle(1);
        check("R10 clear ignored on level source", 64'(irq_out[9]), 64'h1);
        access(1'b0, 12'h3A0, 2'd1, 64'h0);
        check("R12 status level in service", rd, 64'h0200);
        @(negedge clk) irq_in[9] = 1'b0;
        idle(2);
        check("R8 level output follows low", 64'(irq_out[9]), 64'h0);

        // R9 polarity on source 12
        access(1'b1, 12'h3E1, 2'd0, 64'h10);
        access(1'b1, 12'h021, 2'd0, 64'hED);
        idle(2);
        check("R9 inverted low input asserts", 64'(irq_out[12]), 64'h1);
        @(negedge clk) irq_in[12] = 1'b1;
        idle(2);
        check("R9 inverted high input clears", 64'(irq_out[12]), 64'h0);
        access(1'b0, 12'h3E0, 2'd1, 64'h0);
        check("R9 polarity readback", rd, 64'h1000);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule